// File: doc/BRIEF.md
# Single-Cycle Integer Execution Core (add / addi / beq / jal)

This block is a small single-cycle processor core. Each rising clock edge executes one 32-bit instruction taken from an internal word-addressed instruction store, indexed by the program counter. The core recognises four operations. The first is a register-register add. The second adds a sign-extended 16-bit constant to a register. The third is an equality branch relative to the next PC. The fourth is a jump that saves a return address. The core keeps thirty-two 32-bit registers, and register zero is hard-wired to zero.

The program is streamed into the instruction store through a valid/ready load port. The port is ready only while the synchronous reset is held. A word moves on every cycle in which both `ld_valid` and `ld_ready` are high. When `ld_ready` is low, `ld_valid` is ignored and nothing is stored; there is no other back-pressure. Once reset is released the core runs from address 0. The current PC, a combinational register read port and a sticky halt flag are visible at the pins. The halt flag rises when the fetched word is not one of the supported operations.

Top module: `mini_exec_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0, all 32 registers become 0 and `halt` becomes low; the instruction store keeps its contents.
- R2: `ld_ready` is high exactly while `rst` is high. A word on `ld_data` is written to word index `ld_addr` only at an edge where both `ld_valid` and `ld_ready` are high. Load attempts while running change nothing.
- R3: A word with bits[31:26]=000000 and bits[5:0]=100000 writes reg[bits 25:21] + reg[bits 20:16] into reg[bits 15:11] and advances the PC by 4. Bits[10:6] are ignored.
- R4: Bits[31:26]=001000 writes reg[bits 25:21] plus the sign-extended bits[15:0] into reg[bits 20:16] and advances the PC by 4.
- R5: With bits[31:26]=000100 and reg[25:21]==reg[20:16], the PC becomes PC+4+4*sign-extended bits[15:0]; negative offsets branch backwards.
- R6: With bits[31:26]=000100 and unequal registers, the PC advances by 4 and no register changes.
- R7: Bits[31:26]=000011 loads the PC with {(PC+4)[31:28], bits[25:0], 2'b00} and writes PC+4 into register 31.
- R8: Register 0 always reads as zero; writes addressed to it have no effect.
- R9: Any other value of bits[31:26], or bits[5:0] other than 100000 under 000000, sets `halt` at that edge. `halt` stays high until reset. While halted, the PC holds and no register is written.
- R10: `dbg_rdata` shows, in the same cycle, the register selected by `dbg_raddr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also opens the load port |
| ld_valid | input | 1 | Load word valid |
| ld_ready | output | 1 | Load port ready (high during reset) |
| ld_addr | input | IMEM_AW | Word index of the word being loaded |
| ld_data | input | 32 | Instruction word being loaded |
| dbg_raddr | input | 5 | Register select for the read port |
| dbg_rdata | output | 32 | Selected register value |
| pc | output | 32 | Current program counter (byte address) |
| halt | output | 1 | Sticky halt flag |

## Verification
The bench builds the core with the default store of 64 words (IMEM_AW=6). This size holds every directed program with room to spare, and it lets the bench fill the whole store with a halting word before each load. Each program therefore ends in a known halt even when control flow goes wrong. The programs cover a backward branch loop with both branch outcomes, negative immediates, a jump-and-link with a skipped word, an illegal function code, and load attempts made after reset.

// File: rtl/mcore_pkg.sv
package mcore_pkg;
  localparam int XW      = 32;
  localparam int NREG    = 32;
  localparam int RAW     = 5;
  localparam int LINKREG = 31;

  localparam logic [5:0] OP_SPECIAL = 6'b000000;
  localparam logic [5:0] OP_ADDI    = 6'b001000;
  localparam logic [5:0] OP_BEQ     = 6'b000100;
  localparam logic [5:0] OP_JAL     = 6'b000011;
  localparam logic [5:0] FN_ADD     = 6'b100000;

  typedef enum logic [2:0] {
    K_ADD, K_ADDI, K_BEQ, K_JAL, K_BAD
  } kind_e;

  typedef struct packed {
    kind_e           kind;
    logic [RAW-1:0]  rs;
    logic [RAW-1:0]  rt;
    logic [RAW-1:0]  rd;
    logic [XW-1:0]   imm;
    logic [25:0]     jidx;
  } dec_t;
endpackage

// File: rtl/mcore_imem.sv
module mcore_imem #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  localparam int DEPTH = 1 << AW;

  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mcore_decode.sv
module mcore_decode
  import mcore_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);
  logic [5:0] opc;
  logic [5:0] fn;

  assign opc = instr[31:26];
  assign fn  = instr[5:0];

  always_comb begin
    dec.rs   = instr[25:21];
    dec.rt   = instr[20:16];
    dec.rd   = instr[15:11];
    dec.imm  = {{16{instr[15]}}, instr[15:0]};
    dec.jidx = instr[25:0];
    unique case (opc)
      OP_SPECIAL: dec.kind = (fn == FN_ADD) ? K_ADD : K_BAD;
      OP_ADDI:    dec.kind = K_ADDI;
      OP_BEQ:     dec.kind = K_BEQ;
      OP_JAL:     dec.kind = K_JAL;
      default:    dec.kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/mcore_regfile.sv
module mcore_regfile
  import mcore_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [RAW-1:0] waddr,
  input  logic [XW-1:0]  wdata,
  input  logic [RAW-1:0] ra_a,
  output logic [XW-1:0]  rd_a,
  input  logic [RAW-1:0] ra_b,
  output logic [XW-1:0]  rd_b,
  input  logic [RAW-1:0] ra_c,
  output logic [XW-1:0]  rd_c
);
  logic [XW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_store
      always_ff @(posedge clk) begin
        if (rst)                              regs[g] <= '0;
        else if (we && waddr == RAW'(g))      regs[g] <= wdata;
      end
    end
  end

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];
  assign rd_c = regs[ra_c];
endmodule

// File: rtl/mcore_nextpc.sv
module mcore_nextpc
  import mcore_pkg::*;
(
  input  logic [XW-1:0] pc,
  input  kind_e         kind,
  input  logic          equal,
  input  logic [XW-1:0] imm,
  input  logic [25:0]   jidx,
  output logic [XW-1:0] pc_plus4,
  output logic [XW-1:0] pc_next
);
  logic [XW-1:0] br_target;
  logic [XW-1:0] j_target;

  assign pc_plus4  = pc + XW'(4);
  assign br_target = pc_plus4 + {imm[XW-3:0], 2'b00};
  assign j_target  = {pc_plus4[31:28], jidx, 2'b00};

  always_comb begin
    unique case (kind)
      K_BEQ:   pc_next = equal ? br_target : pc_plus4;
      K_JAL:   pc_next = j_target;
      K_BAD:   pc_next = pc;
      default: pc_next = pc_plus4;
    endcase
  end
endmodule

// File: rtl/mini_exec_core.sv
module mini_exec_core
  import mcore_pkg::*;
#(
  parameter int IMEM_AW = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_valid,
  output logic               ld_ready,
  input  logic [IMEM_AW-1:0] ld_addr,
  input  logic [31:0]        ld_data,
  input  logic [4:0]         dbg_raddr,
  output logic [31:0]        dbg_rdata,
  output logic [31:0]        pc,
  output logic               halt
);
  logic [XW-1:0]      pc_q;
  logic               halt_q;
  logic [31:0]        cur_instr;
  dec_t               dec;
  logic [XW-1:0]      rs_val, rt_val;
  logic [XW-1:0]      sum;
  logic [XW-1:0]      pc_plus4, pc_next;
  logic               rf_we;
  logic [RAW-1:0]     rf_waddr;
  logic [XW-1:0]      rf_wdata;
  logic               stepping;

  assign ld_ready = rst;

  mcore_imem #(.AW(IMEM_AW)) u_imem (
    .clk   (clk),
    .we    (ld_valid && ld_ready),
    .waddr (ld_addr),
    .wdata (ld_data),
    .raddr (pc_q[IMEM_AW+1:2]),
    .rdata (cur_instr)
  );

  mcore_decode u_dec (
    .instr (cur_instr),
    .dec   (dec)
  );

  mcore_regfile u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .ra_a  (dec.rs),
    .rd_a  (rs_val),
    .ra_b  (dec.rt),
    .rd_b  (rt_val),
    .ra_c  (dbg_raddr),
    .rd_c  (dbg_rdata)
  );

  mcore_nextpc u_npc (
    .pc       (pc_q),
    .kind     (dec.kind),
    .equal    (rs_val == rt_val),
    .imm      (dec.imm),
    .jidx     (dec.jidx),
    .pc_plus4 (pc_plus4),
    .pc_next  (pc_next)
  );

  assign stepping = !halt_q && (dec.kind != K_BAD);
  assign sum      = rs_val + ((dec.kind == K_ADD) ? rt_val : dec.imm);

  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = dec.rd;
    rf_wdata = sum;
    if (!halt_q) begin
      unique case (dec.kind)
        K_ADD:  begin rf_we = 1'b1; rf_waddr = dec.rd; end
        K_ADDI: begin rf_we = 1'b1; rf_waddr = dec.rt; end
        K_JAL:  begin rf_we = 1'b1; rf_waddr = RAW'(LINKREG); rf_wdata = pc_plus4; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      halt_q <= 1'b0;
    end else begin
      if (stepping) pc_q <= pc_next;
      if (dec.kind == K_BAD) halt_q <= 1'b1;
    end
  end

  assign pc   = pc_q;
  assign halt = halt_q;
endmodule

// File: rtl/mcore_checker.sv
module mcore_checker (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic        halt,
  input logic [4:0]  dbg_raddr,
  input logic [31:0] dbg_rdata,
  input logic [5:0]  op,
  input logic        we,
  input logic [4:0]  waddr
);
  assert_r0_zero_R8: assert property (@(posedge clk) disable iff (rst)
    dbg_raddr == 5'd0 |-> dbg_rdata == 32'd0);

  assert_pc_aligned_R5: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);

  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt && $stable(pc));

  assert_halt_nowrite_R9: assert property (@(posedge clk) disable iff (rst)
    halt |-> !we);

  assert_addi_step_R4: assert property (@(posedge clk) disable iff (rst)
    (!halt && op == 6'b001000) |=> pc == $past(pc) + 32'd4);

  assert_jal_link_R7: assert property (@(posedge clk) disable iff (rst)
    (!halt && op == 6'b000011) |-> (we && waddr == 5'd31));
endmodule

bind mini_exec_core mcore_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .pc        (pc),
  .halt      (halt),
  .dbg_raddr (dbg_raddr),
  .dbg_rdata (dbg_rdata),
  .op        (cur_instr[31:26]),
  .we        (rf_we),
  .waddr     (rf_waddr)
);

// File: tb/mini_exec_core_tb.sv
`timescale 1ns/1ps
module mini_exec_core_tb;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;
  localparam logic [31:0] HALTW = 32'hFC00_0000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_valid = 1'b0;
  logic          ld_ready;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0]   ld_data = '0;
  logic [4:0]    dbg_raddr = '0;
  logic [31:0]   dbg_rdata;
  logic [31:0]   pc;
  logic          halt;

  int checks = 0;
  int errors = 0;
  logic [31:0] prog [DEPTH];

  always #2.5 clk = ~clk;

  mini_exec_core #(.IMEM_AW(AW)) u_dut (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_data(ld_data), .dbg_raddr(dbg_raddr),
    .dbg_rdata(dbg_rdata), .pc(pc), .halt(halt)
  );

  function automatic logic [31:0] enc_add(int rs, int rt, int rd);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'b00000, 6'b100000};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_jal(int idx);
    return {6'b000011, 26'(idx)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_reg(int r, output logic [31:0] v);
    dbg_raddr = 5'(r);
    #0.5;
    v = dbg_rdata;
  endtask

  task automatic check_reg(string req, int r, logic [31:0] exp);
    logic [31:0] v;
    rd_reg(r, v);
    check(req, v, exp);
  endtask

  task automatic clear_prog();
    for (int i = 0; i < DEPTH; i++) prog[i] = HALTW;
  endtask

  // hold reset, stream the whole store in, then release
  task automatic load_and_start();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      ld_valid = 1'b1; ld_addr = AW'(i); ld_data = prog[i];
      @(negedge clk);
    end
    ld_valid = 1'b0;
    rst = 1'b0;
  endtask

  task automatic run(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 pc", pc, 32'd0);
    check("R1 halt", {31'd0, halt}, 32'd0);
    check("R2 ready in reset", {31'd0, ld_ready}, 32'd1);
    for (int r = 0; r < 32; r++) check_reg("R1 reg", r, 32'd0);
  endtask

  task automatic t_arith();
    clear_prog();
    prog[0] = enc_i(6'b001000, 0, 2, 5);
    prog[1] = enc_i(6'b001000, 0, 3, -3);
    prog[2] = enc_add(2, 3, 1);
    prog[3] = enc_add(3, 3, 4);
    prog[4] = enc_i(6'b001000, 2, 0, 7);
    prog[5] = enc_add(2, 2, 0) | 32'h0000_07C0; // shift field set, ignored
    load_and_start();
    check("R2 ready while running", {31'd0, ld_ready}, 32'd0);
    check_reg("R10 fresh", 2, 32'd0);
    run(1);
    check("R4 pc+4", pc, 32'd4);
    check_reg("R4 addi", 2, 32'd5);
    check_reg("R10 same cycle", 2, 32'd5);
    run(5);
    check_reg("R4 negative imm", 3, 32'hFFFF_FFFD);
    check_reg("R3 add", 1, 32'd2);
    check_reg("R3 add neg", 4, 32'hFFFF_FFFA);
    check_reg("R8 r0", 0, 32'd0);
    check("R3 pc", pc, 32'd24);
    run(1);
    check("R9 halt on bad op", {31'd0, halt}, 32'd1);
    check("R9 pc frozen", pc, 32'd24);
  endtask

  task automatic t_branch();
    clear_prog();
    prog[0] = enc_i(6'b001000, 0, 1, 3);
    prog[1] = enc_i(6'b001000, 0, 2, 0);
    prog[2] = enc_i(6'b001000, 2, 2, 1);
    prog[3] = enc_i(6'b000100, 2, 1, 1);
    prog[4] = enc_i(6'b000100, 0, 0, -3);
    prog[5] = enc_i(6'b001000, 0, 5, 9);
    load_and_start();
    // attempt to overwrite word 5 while running: must be dropped
    ld_valid = 1'b1; ld_addr = AW'(5); ld_data = enc_i(6'b001000, 0, 5, 77);
    run(4);
    ld_valid = 1'b0;
    check("R6 not taken pc", pc, 32'd16);
    check_reg("R6 no write", 2, 32'd1);
    run(1);
    check("R5 backward branch", pc, 32'd8);
    run(6);
    check("R5 taken forward", pc, 32'd24);
    check_reg("R5 loop count", 2, 32'd3);
    check_reg("R2 load ignored", 5, 32'd9);
    run(1);
    check("R9 halt", {31'd0, halt}, 32'd1);
  endtask

  task automatic t_jal();
    clear_prog();
    prog[0] = enc_i(6'b001000, 0, 1, 1);
    prog[1] = enc_jal(4);
    prog[2] = enc_i(6'b001000, 0, 1, 99);
    prog[4] = enc_i(6'b001000, 0, 6, 7);
    load_and_start();
    run(2);
    check("R7 target", pc, 32'd16);
    check_reg("R7 link", 31, 32'd8);
    run(1);
    check_reg("R7 skipped word", 1, 32'd1);
    check_reg("R7 landed", 6, 32'd7);
    run(2);
    check("R9 pc frozen", pc, 32'd20);
  endtask

  task automatic t_badfn();
    clear_prog();
    prog[0] = enc_i(6'b001000, 0, 1, 1);
    prog[1] = {6'b000000, 5'd1, 5'd1, 5'd2, 5'd0, 6'b100010};
    prog[2] = enc_i(6'b001000, 0, 3, 4);
    load_and_start();
    run(1);
    check("R9 before", {31'd0, halt}, 32'd0);
    run(1);
    check("R9 bad funct halts", {31'd0, halt}, 32'd1);
    check("R9 pc held", pc, 32'd4);
    run(5);
    check("R9 still halted", {31'd0, halt}, 32'd1);
    check("R9 pc still", pc, 32'd4);
    check_reg("R9 no write", 2, 32'd0);
    check_reg("R9 no later write", 3, 32'd0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1 halt cleared", {31'd0, halt}, 32'd0);
    check_reg("R1 reg cleared", 1, 32'd0);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_arith();
    t_branch();
    t_jal();
    t_badfn();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule